// File: doc/BRIEF.md
# Multi-Port Shared Memory with Selectable Conflict Model

This block is a small shared register-file memory that several processor ports reach in parallel. Every port may issue one read or one write on every clock. When two or more ports name the same word in the same cycle, a static model input chooses how the clash is settled. The exclusive model serves only one access per word. The concurrent-read model lets readers share a word but allows only one writer to it. The fully concurrent model accepts every access and merges colliding writes into one stored value, under a selectable rule.

The merge rules are: a pseudo-randomly chosen writer, the lowest-indexed writer, the largest value written, or the wrapped sum of all values written. Each port receives a registered response one cycle after its request: read data, a grant flag and an error flag. Reads see the memory as it was before the writes of their own cycle.

Top module: `pram_front`

## Requirements
- R1: After reset every memory word reads as zero, every response output is zero, and the random generator holds 16'hACE1.
- R2: Responses are registered and appear one cycle after the request. A read returns the word's value from before that cycle's writes. A port that did not request, or whose read was not granted, returns grant 0 and read data 0, and an idle port also returns error 0.
- R3: With model code 0 (exclusive), at each address only the lowest-indexed requester is granted, whether it reads or writes. Every other requester to that address gets error 1 and no effect. Model code 3 behaves exactly like code 0.
- R4: With model code 1 (concurrent read), every read is granted, and all reads of one address return the same data.
- R5: With model code 1, among writers to one address only the lowest-indexed writer is granted and commits. The others get error 1 and do not change memory.
- R6: With model code 2 (concurrent), every request is granted and none errs. Writers to different addresses form independent groups, and each group commits one merged value.
- R7: Policy code 1 (first) stores the value of the lowest-indexed writer in the group.
- R8: Policy code 2 (largest) stores the largest written value, compared as unsigned.
- R9: Policy code 3 (total) stores the sum of all written values, modulo 2^W.
- R10: Policy code 0 (random) uses a 16-bit register L that shifts each cycle after reset to {L[14:0], L[15]^L[13]^L[12]^L[10]}. The value of L before a clock edge, taken modulo the group size, selects the winning writer, ranked from 0 in ascending port order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| model_i | input | 2 | Conflict model: 0 exclusive, 1 concurrent read, 2 concurrent, 3 same as 0 |
| policy_i | input | 2 | Merge rule in model 2: 0 random, 1 first, 2 largest, 3 total |
| req_valid_i | input | N | Per-port request strobe |
| req_wr_i | input | N | Per-port write (1) or read (0) |
| req_addr_i | input | N*AW | Per-port word address, port p in bits [p*AW +: AW] |
| req_wdata_i | input | N*W | Per-port write data, port p in bits [p*W +: W] |
| rsp_rdata_o | output | N*W | Per-port read data, one cycle later |
| rsp_grant_o | output | N | Per-port access granted, one cycle later |
| rsp_err_o | output | N | Per-port access rejected, one cycle later |

## Verification
The assertions assume that the model and policy inputs hold steady whenever a request is pending, and that inputs are quiet while reset is applied. Under these conditions a past request can be matched with its registered response in the next cycle. The bench changes model and policy only between scenarios, with all strobes low, and it keeps every strobe low while reset is active. It clears all requests after each exercised cycle, so each response can be traced to one known set of requests.

// File: rtl/pram_pkg.sv
package pram_pkg;

    typedef enum logic [1:0] {
        MD_EXCL  = 2'd0,
        MD_CREAD = 2'd1,
        MD_CONC  = 2'd2,
        MD_RSVD  = 2'd3
    } model_e;

    typedef enum logic [1:0] {
        CB_RANDOM  = 2'd0,
        CB_FIRST   = 2'd1,
        CB_LARGEST = 2'd2,
        CB_TOTAL   = 2'd3
    } policy_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/pram_lfsr.sv
module pram_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] state_o
);
    logic [15:0] state_d, state_q;

    always_comb begin
        state_d = {state_q[14:0], state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // R10
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 16'd0);
endmodule

// File: rtl/pram_conflict.sv
module pram_conflict #(
    parameter int N  = 4,
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       model_i,
    input  logic [N-1:0]     valid_i,
    input  logic [N-1:0]     wr_i,
    input  logic [N*AW-1:0]  addr_i,
    output logic [N-1:0]     grant_o,
    output logic [N-1:0]     err_o,
    output logic [N-1:0]     wlead_o
);
    import pram_pkg::*;

    logic [N-1:0] any_lo;
    logic [N-1:0] wr_lo;

    // find earlier requesters that share this port's address
    always_comb begin
        for (int i = 0; i < N; i++) begin
            any_lo[i] = 1'b0;
            wr_lo[i]  = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (valid_i[j] && (addr_i[j*AW +: AW] == addr_i[i*AW +: AW])) begin
                    any_lo[i] = 1'b1;
                    if (wr_i[j]) wr_lo[i] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            grant_o[i] = 1'b0;
            err_o[i]   = 1'b0;
            if (valid_i[i]) begin
                case (model_e'(model_i))
                    MD_CREAD: begin
                        if (wr_i[i] && wr_lo[i]) err_o[i]   = 1'b1;
                        else                     grant_o[i] = 1'b1;
                    end
                    MD_CONC: grant_o[i] = 1'b1;
                    default: begin
                        if (any_lo[i]) err_o[i]   = 1'b1;
                        else           grant_o[i] = 1'b1;
                    end
                endcase
            end
            wlead_o[i] = valid_i[i] && wr_i[i] && grant_o[i] && !wr_lo[i];
        end
    end

    // R6: at most one committing writer per address in a cycle
    for (genvar a = 0; a < N; a++) begin : g_pa
        for (genvar b = a + 1; b < N; b++) begin : g_pb
            lead_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wlead_o[a] && wlead_o[b]) |-> (addr_i[a*AW +: AW] != addr_i[b*AW +: AW]));
        end
    end
endmodule

// File: rtl/pram_combine.sv
module pram_combine #(
    parameter int N  = 4,
    parameter int AW = 4,
    parameter int W  = 16
) (
    input  logic [N-1:0]    valid_i,
    input  logic [N-1:0]    wr_i,
    input  logic [N*AW-1:0] addr_i,
    input  logic [N*W-1:0]  wdata_i,
    input  logic [1:0]      policy_i,
    input  logic [15:0]     lfsr_i,
    output logic [N*W-1:0]  merged_o
);
    import pram_pkg::*;

    localparam int CW = $clog2(N + 1);

    always_comb begin
        logic [CW-1:0] cnt_v;
        logic [15:0]   sel_v;
        logic [15:0]   rank_v;
        logic [W-1:0]  pick_v, max_v, sum_v;
        logic          mem_v;
        for (int i = 0; i < N; i++) begin
            cnt_v = '0;
            for (int j = 0; j < N; j++) begin
                mem_v = valid_i[i] && wr_i[i] && valid_i[j] && wr_i[j] &&
                        (addr_i[j*AW +: AW] == addr_i[i*AW +: AW]);
                if (mem_v) cnt_v = cnt_v + CW'(1);
            end
            sel_v = '0;
            if (cnt_v != '0) sel_v = lfsr_i % {{(16-CW){1'b0}}, cnt_v};
            rank_v = '0;
            pick_v = wdata_i[i*W +: W];
            max_v  = '0;
            sum_v  = '0;
            for (int j = 0; j < N; j++) begin
                mem_v = valid_i[i] && wr_i[i] && valid_i[j] && wr_i[j] &&
                        (addr_i[j*AW +: AW] == addr_i[i*AW +: AW]);
                if (mem_v) begin
                    if (rank_v == sel_v) pick_v = wdata_i[j*W +: W];
                    rank_v = rank_v + 16'd1;
                    if (wdata_i[j*W +: W] > max_v) max_v = wdata_i[j*W +: W];
                    sum_v = sum_v + wdata_i[j*W +: W];
                end
            end
            case (policy_e'(policy_i))
                CB_RANDOM:  merged_o[i*W +: W] = pick_v;
                CB_LARGEST: merged_o[i*W +: W] = max_v;
                CB_TOTAL:   merged_o[i*W +: W] = sum_v;
                default:    merged_o[i*W +: W] = wdata_i[i*W +: W];
            endcase
        end
    end
endmodule

// File: rtl/pram_front.sv
module pram_front #(
    parameter int N  = 4,
    parameter int AW = 4,
    parameter int W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       model_i,
    input  logic [1:0]       policy_i,
    input  logic [N-1:0]     req_valid_i,
    input  logic [N-1:0]     req_wr_i,
    input  logic [N*AW-1:0]  req_addr_i,
    input  logic [N*W-1:0]   req_wdata_i,
    output logic [N*W-1:0]   rsp_rdata_o,
    output logic [N-1:0]     rsp_grant_o,
    output logic [N-1:0]     rsp_err_o
);
    import pram_pkg::*;

    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [N-1:0][W-1:0]     rdata;
        logic [N-1:0]            grant;
        logic [N-1:0]            err;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]   grant_c, err_c, wlead_c;
    logic [N*W-1:0] merged_c;
    logic [15:0]    lfsr_c;

    pram_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (lfsr_c)
    );

    pram_conflict #(.N(N), .AW(AW)) u_conf (
        .clk     (clk),
        .rst_n   (rst_n),
        .model_i (model_i),
        .valid_i (req_valid_i),
        .wr_i    (req_wr_i),
        .addr_i  (req_addr_i),
        .grant_o (grant_c),
        .err_o   (err_c),
        .wlead_o (wlead_c)
    );

    pram_combine #(.N(N), .AW(AW), .W(W)) u_comb (
        .valid_i  (req_valid_i),
        .wr_i     (req_wr_i),
        .addr_i   (req_addr_i),
        .wdata_i  (req_wdata_i),
        .policy_i (policy_i),
        .lfsr_i   (lfsr_c),
        .merged_o (merged_c)
    );

    always_comb begin
        st_d = st_q;
        st_d.grant = grant_c;
        st_d.err   = err_c;
        for (int i = 0; i < N; i++) begin
            // reads see the pre-write contents
            if (grant_c[i] && !req_wr_i[i])
                st_d.rdata[i] = st_q.mem[req_addr_i[i*AW +: AW]];
            else
                st_d.rdata[i] = '0;
        end
        for (int i = 0; i < N; i++) begin
            if (wlead_c[i]) begin
                if (model_e'(model_i) == MD_CONC)
                    st_d.mem[req_addr_i[i*AW +: AW]] = merged_c[i*W +: W];
                else
                    st_d.mem[req_addr_i[i*AW +: AW]] = req_wdata_i[i*W +: W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_rdata_o = st_q.rdata;
    assign rsp_grant_o = st_q.grant;
    assign rsp_err_o   = st_q.err;

    for (genvar p = 0; p < N; p++) begin : g_chk
        // R2
        idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(req_valid_i[p]) |-> (!rsp_grant_o[p] && !rsp_err_o[p]));
        // R3
        grant_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(rsp_grant_o[p] && rsp_err_o[p]));
        // R4
        crew_read_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(model_i == 2'd1 && req_valid_i[p] && !req_wr_i[p]) |->
            (rsp_grant_o[p] && !rsp_err_o[p]));
        // R6
        crcw_all_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(model_i == 2'd2 && req_valid_i[p]) |-> (rsp_grant_o[p] && !rsp_err_o[p]));
    end

    // R3
    port0_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid_i[0]) |-> rsp_grant_o[0]);
endmodule

// File: tb/sim_pram_front.sv
`timescale 1ns/1ps
module sim_pram_front;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] model = 2'd0;
    logic [1:0] policy = 2'd0;
    logic [N-1:0] vld = '0;
    logic [N-1:0] wr = '0;
    logic [AW-1:0] ad [N];
    logic [W-1:0]  wd [N];
    logic [N*AW-1:0] addr_f;
    logic [N*W-1:0]  wdata_f;
    logic [N*W-1:0]  rdata_f;
    logic [N-1:0]    grant, err;

    int n_run = 0;
    int n_bad = 0;
    logic [15:0] lfsr_m;

    always #10 clk = ~clk;

    always_comb begin
        for (int p = 0; p < N; p++) begin
            addr_f[p*AW +: AW] = ad[p];
            wdata_f[p*W +: W]  = wd[p];
        end
    end

    // independent model of the random generator (R10)
    always @(posedge clk) begin
        if (!rst_n) lfsr_m <= 16'hACE1;
        else lfsr_m <= {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
    end

    pram_front #(.N(N), .AW(AW), .W(W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .model_i     (model),
        .policy_i    (policy),
        .req_valid_i (vld),
        .req_wr_i    (wr),
        .req_addr_i  (addr_f),
        .req_wdata_i (wdata_f),
        .rsp_rdata_o (rdata_f),
        .rsp_grant_o (grant),
        .rsp_err_o   (err)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        vld = '0;
        wr  = '0;
        for (int p = 0; p < N; p++) begin
            ad[p] = '0;
            wd[p] = '0;
        end
    endtask

    task automatic req(int p, bit w, int a, int d);
        vld[p] = 1'b1;
        wr[p]  = w;
        ad[p]  = AW'(a);
        wd[p]  = W'(d);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_all();
    endtask

    function automatic logic [W-1:0] rd(int p);
        return rdata_f[p*W +: W];
    endfunction

    task automatic read_word(int a, output logic [W-1:0] v);
        idle_all();
        req(0, 1'b0, a, 0);
        step();
        v = rd(0);
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        check("R1 grant after reset", 32'(grant), 32'h0);
        check("R1 err after reset", 32'(err), 32'h0);
        check("R1 rdata after reset", rdata_f[31:0], 32'h0);
        check("R1 lfsr seed", 32'(lfsr_m), 32'hACE1);
        read_word(12, v);
        check("R1 memory word zero", 32'(v), 32'h0);
    endtask

    task automatic t_excl();
        logic [W-1:0] v;
        model = 2'd0;
        req(0, 1'b1, 3, 16'h0011);
        step();
        check("R2 idle port quiet", 32'(grant[3:1] | err[3:1]), 32'h0);
        req(0, 1'b0, 3, 0);
        req(1, 1'b0, 3, 0);
        req(2, 1'b1, 3, 16'h0022);
        req(3, 1'b0, 4, 0);
        step();
        check("R3 exclusive grants", 32'(grant), 32'b1001);
        check("R3 exclusive errors", 32'(err), 32'b0110);
        check("R3 winner read data", 32'(rd(0)), 32'h0011);
        check("R2 ungranted read data zero", 32'(rd(1)), 32'h0);
        read_word(3, v);
        check("R3 rejected write no effect", 32'(v), 32'h0011);
        model = 2'd3;
        req(0, 1'b0, 3, 0);
        req(1, 1'b1, 3, 16'h0033);
        step();
        check("R3 code 3 grants", 32'(grant), 32'b0001);
        check("R3 code 3 errors", 32'(err), 32'b0010);
        read_word(3, v);
        check("R3 code 3 write blocked", 32'(v), 32'h0011);
    endtask

    task automatic t_cread();
        logic [W-1:0] v;
        model = 2'd1;
        for (int p = 0; p < N; p++) req(p, 1'b0, 3, 0);
        step();
        check("R4 all readers granted", 32'(grant), 32'hF);
        check("R4 no reader errors", 32'(err), 32'h0);
        for (int p = 0; p < N; p++) check("R4 shared read data", 32'(rd(p)), 32'h0011);
        req(0, 1'b0, 5, 0);
        req(1, 1'b1, 5, 16'h00A1);
        req(2, 1'b1, 5, 16'h00A2);
        req(3, 1'b1, 5, 16'h00A3);
        step();
        check("R2 read before write", 32'(rd(0)), 32'h0);
        check("R5 writer grants", 32'(grant), 32'b0011);
        check("R5 writer errors", 32'(err), 32'b1100);
        read_word(5, v);
        check("R5 lowest writer commits", 32'(v), 32'h00A1);
    endtask

    task automatic t_conc();
        logic [W-1:0] v;
        logic [W-1:0] grp [3];
        model = 2'd2;
        policy = 2'd1;
        req(0, 1'b0, 6, 0);
        req(1, 1'b1, 6, 16'h0055);
        req(2, 1'b1, 6, 16'h0066);
        req(3, 1'b1, 6, 16'h0077);
        step();
        check("R6 all granted", 32'(grant), 32'hF);
        check("R6 no errors", 32'(err), 32'h0);
        read_word(6, v);
        check("R7 first writer stored", 32'(v), 32'h0055);
        req(0, 1'b1, 7, 16'h0001);
        req(1, 1'b1, 8, 16'h0002);
        req(2, 1'b1, 7, 16'h0003);
        req(3, 1'b1, 8, 16'h0004);
        step();
        read_word(7, v);
        check("R6 group A independent", 32'(v), 32'h0001);
        read_word(8, v);
        check("R6 group B independent", 32'(v), 32'h0002);
        policy = 2'd2;
        req(0, 1'b1, 10, 16'h0010);
        req(1, 1'b1, 10, 16'h8000);
        req(2, 1'b1, 10, 16'h7FFF);
        req(3, 1'b1, 10, 16'h0003);
        step();
        read_word(10, v);
        check("R8 largest unsigned", 32'(v), 32'h8000);
        policy = 2'd3;
        req(0, 1'b1, 11, 16'hFFFF);
        req(1, 1'b1, 11, 16'h0002);
        req(2, 1'b1, 11, 16'h0003);
        req(3, 1'b1, 11, 16'h0000);
        step();
        read_word(11, v);
        check("R9 wrapped total", 32'(v), 32'h0004);
        policy = 2'd0;
        grp[0] = 16'h0100;
        grp[1] = 16'h0200;
        grp[2] = 16'h0300;
        for (int k = 0; k < 3; k++) begin
            logic [W-1:0] e;
            repeat (k) @(negedge clk);
            req(0, 1'b1, 9, grp[0]);
            req(2, 1'b1, 9, grp[1]);
            req(3, 1'b1, 9, grp[2]);
            e = grp[lfsr_m % 16'd3];
            step();
            check("R10 random grants", 32'(grant), 32'b1101);
            read_word(9, v);
            check("R10 random winner", 32'(v), 32'(e));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        idle_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_excl();
        t_cread();
        t_conc();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule